// File: doc/BRIEF.md
# Graceful Reset Button Controller

This block turns a raw, active-low reset button into one system reset request. First it synchronizes the button and filters out contact bounce. Then it waits for the devices it guards to go quiet before it issues the reset. Each device supplies one idle bit. When the filtered press is recognized and every device is already idle, the reset request goes out at once. If any device is still busy, the block opens a bounded waiting window. The reset goes out as soon as all devices report idle. When the window runs out first, the reset is forced and a flag marks it as forced.

A press that has produced a reset cannot produce another one. The filtered button must be seen released first, and then a fresh press is needed. The filter interval and the waiting window are both parameters counted in clock ticks. How the reset is distributed and how devices reach the idle state are handled outside this block.

Top module: `grace_rst_ctrl`

## Requirements
- R1: The button input (`btn_ni`, low = pressed) passes a two-flop synchronizer. The filtered level changes only after the synchronized level has differed from it for DEB_TICKS consecutive clocks. Any shorter excursion is ignored and starts no sequence.
- R2: If every bit of `dev_idle_i` is 1 (1 = idle) in the cycle the filtered press is first seen, `rst_req_o` pulses on the next clock. `wait_busy_o` stays low and `forced_o` is 0.
- R3: If any device is busy when the press is detected, `wait_busy_o` rises on the next clock and stays high for the whole waiting window.
- R4: While waiting, the first clock that samples all idle bits at 1 ends the window with a graceful `rst_req_o` pulse, with `forced_o` = 0.
- R5: If the devices are still not all idle, `wait_busy_o` stays high for exactly WAIT_TICKS cycles. `rst_req_o` then pulses with `forced_o` = 1.
- R6: `rst_req_o` is high for exactly one cycle. `wait_busy_o` falls on the same edge, and the block never waits after a pulse.
- R7: A press that is held after its reset starts no further sequence. A new sequence needs a filtered release followed by a new filtered press.
- R8: `forced_o` is updated together with each `rst_req_o` pulse and keeps its value until the next filtered press is detected, which clears it.
- R9: If all devices turn idle in the same cycle in which the window would expire, the reset counts as graceful (`forced_o` = 0).
- R10: During and after reset (`rst_ni` low), `rst_req_o`, `wait_busy_o` and `forced_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| btn_ni | input | 1 | Raw reset button, low when pressed |
| dev_idle_i | input | N_DEV | Per-device idle indicators, 1 = idle |
| rst_req_o | output | 1 | Single-cycle system reset request |
| wait_busy_o | output | 1 | High while waiting for devices to go idle |
| forced_o | output | 1 | The last reset request was forced by timeout |

## Verification
The idle-detection path and the window-expiry path can both fire on the same clock edge. The bench sets up that collision by counting the cycles in which `wait_busy_o` is seen high. Once the count reaches WAIT_TICKS, which is the last cycle of the window, it raises every idle bit. The outcome is judged by requiring a single pulse with `forced_o` low after exactly WAIT_TICKS busy cycles. The neighbouring cases of one cycle earlier and of a partial idle mask at the same point check that the tie-break is exact.

// File: rtl/grace_rst_pkg.sv
package grace_rst_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_HOLD = 2'd2
  } seq_st_e;

  // True when a counter started at zero has spent lim ticks (lim >= 1).
  function automatic logic lim_hit(input logic [31:0] cnt, input logic [31:0] lim);
    return (cnt + 32'd1) >= lim;
  endfunction

endpackage

// File: rtl/grace_debounce.sv
module grace_debounce #(
  parameter int unsigned DEB_TICKS = 2_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_ni,
  output logic sync_o,
  output logic pressed_o
);
  import grace_rst_pkg::*;

  localparam int unsigned CW = $clog2(DEB_TICKS + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          db_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], ~raw_ni};
    end
  end

  assign sync_o = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      db_q  <= 1'b0;
    end else if (sync_o == db_q) begin
      cnt_q <= '0;
    end else if (lim_hit(32'(cnt_q), DEB_TICKS)) begin
      db_q  <= sync_o;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pressed_o = db_q;

endmodule

// File: rtl/grace_seq.sv
module grace_seq #(
  parameter int unsigned N_DEV      = 4,
  parameter int unsigned WAIT_TICKS = 1_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pressed_i,
  input  logic [N_DEV-1:0] dev_idle_i,
  output logic             press_evt_o,
  output logic             expire_o,
  output logic             rst_req_o,
  output logic             busy_o,
  output logic             forced_o
);
  import grace_rst_pkg::*;

  localparam int unsigned TW = $clog2(WAIT_TICKS + 1);

  seq_st_e       st_q;
  logic [TW-1:0] tcnt_q;
  logic          press_q;
  logic          all_idle;

  assign all_idle    = &dev_idle_i;
  assign press_evt_o = pressed_i & ~press_q;
  assign expire_o    = (st_q == SQ_WAIT) && lim_hit(32'(tcnt_q), WAIT_TICKS);
  assign busy_o      = (st_q == SQ_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      press_q <= 1'b0;
    end else begin
      press_q <= pressed_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= SQ_IDLE;
      tcnt_q    <= '0;
      rst_req_o <= 1'b0;
      forced_o  <= 1'b0;
    end else begin
      rst_req_o <= 1'b0;
      unique case (st_q)
        SQ_IDLE: begin
          if (press_evt_o) begin
            forced_o <= 1'b0;
            if (all_idle) begin
              rst_req_o <= 1'b1;
              st_q      <= SQ_HOLD;
            end else begin
              tcnt_q <= '0;
              st_q   <= SQ_WAIT;
            end
          end
        end
        SQ_WAIT: begin
          if (all_idle) begin
            rst_req_o <= 1'b1;
            st_q      <= SQ_HOLD;
          end else if (expire_o) begin
            rst_req_o <= 1'b1;
            forced_o  <= 1'b1;
            st_q      <= SQ_HOLD;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        SQ_HOLD: begin
          if (!pressed_i) st_q <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/grace_rst_ctrl.sv
module grace_rst_ctrl #(
  parameter int unsigned N_DEV      = 4,
  parameter int unsigned DEB_TICKS  = 2_000_000,
  parameter int unsigned WAIT_TICKS = 1_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             btn_ni,
  input  logic [N_DEV-1:0] dev_idle_i,
  output logic             rst_req_o,
  output logic             wait_busy_o,
  output logic             forced_o
);

  logic btn_sync;
  logic pressed_db;
  logic press_evt;
  logic wait_expire;

  grace_debounce #(.DEB_TICKS(DEB_TICKS)) deb_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raw_ni    (btn_ni),
    .sync_o    (btn_sync),
    .pressed_o (pressed_db)
  );

  grace_seq #(.N_DEV(N_DEV), .WAIT_TICKS(WAIT_TICKS)) seq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pressed_i   (pressed_db),
    .dev_idle_i  (dev_idle_i),
    .press_evt_o (press_evt),
    .expire_o    (wait_expire),
    .rst_req_o   (rst_req_o),
    .busy_o      (wait_busy_o),
    .forced_o    (forced_o)
  );

endmodule

// File: rtl/grace_rst_chk.sv
module grace_rst_chk #(
  parameter int unsigned N_DEV      = 4,
  parameter int unsigned DEB_TICKS  = 2_000_000,
  parameter int unsigned WAIT_TICKS = 1_000_000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_DEV-1:0] dev_idle_i,
  input logic             rst_req_o,
  input logic             wait_busy_o,
  input logic             forced_o,
  input logic             btn_sync,
  input logic             pressed_db,
  input logic             press_evt,
  input logic             wait_expire
);

  int unsigned busy_run;
  int unsigned sync_run;
  logic        sync_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_run  <= 0;
      sync_run  <= 0;
      sync_prev <= 1'b0;
    end else begin
      busy_run  <= wait_busy_o ? busy_run + 1 : 0;
      sync_prev <= btn_sync;
      if (btn_sync != sync_prev) sync_run <= 0;
      else if (sync_run < DEB_TICKS + 4) sync_run <= sync_run + 1;
    end
  end

  // R1
  deb_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(pressed_db) |-> (sync_run + 2 >= DEB_TICKS));

  // R3
  wait_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wait_busy_o) |-> $past(press_evt));

  // R5
  wait_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run <= WAIT_TICKS);

  // R6
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  // R6
  wait_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wait_busy_o) |-> rst_req_o);

  // R9
  forced_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (forced_o == !(&$past(dev_idle_i))));

  // R8
  forced_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_req_o && !$past(press_evt)) |-> $stable(forced_o));

  // R5
  expire_use_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_expire && !(&dev_idle_i)) |=> (rst_req_o && forced_o));

endmodule

bind grace_rst_ctrl grace_rst_chk #(
  .N_DEV(N_DEV), .DEB_TICKS(DEB_TICKS), .WAIT_TICKS(WAIT_TICKS)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dev_idle_i  (dev_idle_i),
  .rst_req_o   (rst_req_o),
  .wait_busy_o (wait_busy_o),
  .forced_o    (forced_o),
  .btn_sync    (btn_sync),
  .pressed_db  (pressed_db),
  .press_evt   (press_evt),
  .wait_expire (wait_expire)
);

// File: tb/grace_rst_ctrl_tb_top.sv
`timescale 1ns/1ps
module grace_rst_ctrl_tb_top;

  localparam int N_DEV = 4;
  localparam int DEB   = 8;
  localparam int WT    = 20;

  typedef struct packed {
    logic [3:0] idle0;   // idle mask at press
    logic [7:0] k;       // busy-sample count at which the mask changes (0 = never)
    logic [3:0] idle_k;  // mask applied at that point
    logic [7:0] ebusy;   // expected busy cycles
    logic       eforce;  // expected forced flag
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{4'hF, 8'd0,      4'hF, 8'd0,      1'b0},  // R2 immediate
    '{4'h0, 8'd0,      4'h0, 8'(WT),    1'b1},  // R5 timeout
    '{4'h0, 8'd5,      4'hF, 8'd5,      1'b0},  // R4 idle mid-window
    '{4'h7, 8'(WT),    4'hF, 8'(WT),    1'b0},  // R9 idle on expiry cycle
    '{4'h3, 8'd3,      4'hE, 8'(WT),    1'b1},  // R5 partial idle
    '{4'hE, 8'd1,      4'hF, 8'd1,      1'b0},  // R4 first cycle
    '{4'h0, 8'(WT-1),  4'hF, 8'(WT-1),  1'b0}   // R4 one before expiry
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_n = 1'b1;
  logic [N_DEV-1:0] idle = '1;
  logic rst_req, busy, forced;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  grace_rst_ctrl #(.N_DEV(N_DEV), .DEB_TICKS(DEB), .WAIT_TICKS(WT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .btn_ni(btn_n), .dev_idle_i(idle),
    .rst_req_o(rst_req), .wait_busy_o(busy), .forced_o(forced)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic quiet(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy || rst_req) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic run_seq(input vec_t v, input int idx);
    int   bn = 0;
    logic got = 1'b0;
    int   hbad = 0;
    idle  = v.idle0;
    btn_n = 1'b0;
    for (int i = 0; i < DEB + WT + 50; i++) begin
      @(negedge clk);
      if (rst_req) begin
        got = 1'b1;
        chk(forced == v.eforce, $sformatf("R8/R9 vec%0d forced", idx), forced, v.eforce);
        chk(bn == int'(v.ebusy), $sformatf("R3/R5 vec%0d busy cycles", idx), bn, v.ebusy);
        chk(!busy, $sformatf("R6 vec%0d busy at pulse", idx), busy, 0);
        break;
      end
      if (busy) begin
        bn++;
        if (bn == 1) chk(!forced, $sformatf("R8 vec%0d flag cleared", idx), forced, 0);
        if (v.k != 0 && bn == int'(v.k)) idle = v.idle_k;
      end
    end
    chk(got, $sformatf("R2/R4 vec%0d pulse seen", idx), got, 1);
    @(negedge clk);
    chk(!rst_req, $sformatf("R6 vec%0d single cycle", idx), rst_req, 0);
    idle = '0;
    for (int i = 0; i < 3 * WT; i++) begin
      @(negedge clk);
      if (busy || rst_req || forced != v.eforce) hbad++;
    end
    chk(hbad == 0, $sformatf("R7/R8 vec%0d held press", idx), hbad, 0);
    btn_n = 1'b1;
    quiet(DEB + 10, $sformatf("R7 vec%0d release", idx));
    idle = '1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-reqs act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!rst_req && !busy && !forced, "R10 in reset", {rst_req, busy, forced}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rst_req && !busy && !forced, "R10 after reset", {rst_req, busy, forced}, 0);

    // R1 bounces shorter than the filter interval
    idle = '0;
    for (int b = 0; b < 6; b++) begin
      btn_n = 1'b0;
      repeat (DEB - 2) @(negedge clk);
      btn_n = 1'b1;
      repeat (2) @(negedge clk);
    end
    quiet(DEB + 20, "R1 bounce ignored");

    // R1 latency of a clean press: 2 sync + DEB filter + 1 sequencer
    lat = 0;
    btn_n = 1'b0;
    while (!busy && lat < DEB + 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == DEB + 3, "R1 press latency", lat, DEB + 3);
    while (!rst_req) @(negedge clk);
    btn_n = 1'b1;
    idle  = '1;
    repeat (DEB + 10) @(negedge clk);

    foreach (VEC[i]) run_seq(VEC[i], i);

    // R10 reset in the middle of a wait
    idle  = '0;
    btn_n = 1'b0;
    while (!busy) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!rst_req && !busy && !forced, "R10 reset mid-wait", {rst_req, busy, forced}, 0);
    btn_n = 1'b1;
    rst_n = 1'b1;
    quiet(DEB + 10, "R10 idle after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule